// File: doc/BRIEF.md
# Memory-Port ID Event Filter

This block watches one memory port and turns selected handshakes into event pulses for a bank of performance counters. It observes the read-address, write-address and read-data channels. It compares the transaction ID on each channel with a programmed ID, under a programmed mask. When the handshake completes and the ID matches, it produces a single-cycle pulse.

There are three filtered events: read transactions, write transactions and read data beats. Each has its own enable bit. Each pulse is wired to the special event code 73 of one fixed counter: read transactions go to counter 2, write transactions to counter 3 and read beats to counter 4. Software sets the mask, the ID and the enables through a small register port. Both registers read back combinationally.

Top module: `axi_id_evt_filter`

## Requirements
- R1: After reset, every register reads zero and all three event outputs are low.
- R2: The register at byte offset 0x00 holds the ID mask in bits 17:0, the read-transaction enable in bit 31, the write-transaction enable in bit 30 and the read-beat enable in bit 29. Bits 28:18 always read zero.
- R3: The register at byte offset 0x04 holds the match ID in bits 17:0; its other bits read zero.
- R4: An ID matches when ((id XOR match ID) AND mask) is zero. A mask bit of 1 compares that ID bit and a mask bit of 0 ignores it.
- R5: `evt_rd_txn` is high for exactly the cycle after each read-address handshake (valid and ready both high on a clock edge) whose ID matches, while bit 31 is set.
- R6: `evt_wr_txn` behaves the same way for write-address handshakes, gated by bit 30.
- R7: `evt_rd_beat` pulses once for every read-data handshake whose ID matches, while bit 29 is set, so a burst of N matching beats gives N pulses.
- R8: A channel with valid high and ready low produces no pulse.
- R9: When an enable bit is 0, its event output stays low whatever the traffic.
- R10: A mask of all zeros makes every ID match.
- R11: Writes to any offset other than 0x00 and 0x04 change no register, and such offsets read zero.
- R12: A register write takes effect for handshakes on the clock edges after the write edge. The handshake on the write edge itself uses the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset, used for writes and reads |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| ar_valid | input | 1 | Read-address valid |
| ar_ready | input | 1 | Read-address ready |
| ar_id | input | 18 | Read-address transaction ID |
| aw_valid | input | 1 | Write-address valid |
| aw_ready | input | 1 | Write-address ready |
| aw_id | input | 18 | Write-address transaction ID |
| r_valid | input | 1 | Read-data valid |
| r_ready | input | 1 | Read-data ready |
| r_id | input | 18 | Read-data transaction ID |
| evt_rd_txn | output | 1 | Filtered read-transaction event (counter 2, code 73) |
| evt_wr_txn | output | 1 | Filtered write-transaction event (counter 3, code 73) |
| evt_rd_beat | output | 1 | Filtered read-beat event (counter 4, code 73) |

## Verification
The directed cases each isolate one effect:
- A four-beat matching read burst shows that the block counts per beat rather than per burst.
- An ID that differs only in a masked-off bit, and one that differs in a compared bit, separate the two halves of the mask rule.
- Valid held without ready separates a handshake from a mere request.
- An all-zero mask shows that every ID then matches.
- Clearing one enable while traffic continues on all three channels shows that each enable gates only its own event.

Random traffic on all three channels together, with random IDs drawn close to the match ID and occasional register rewrites mid-stream, checks that the channels stay independent. It also checks when a register write takes effect.

// File: rtl/axi_id_evt_pkg.sv
package axi_id_evt_pkg;
  localparam int unsigned FLT_ID_W   = 18;
  localparam int unsigned FLT_DATA_W = 32;
  localparam int unsigned FLT_LANES  = 3;

  // Lane order: read transaction, write transaction, read beat.
  typedef enum logic [1:0] {
    LANE_RD_TXN  = 2'd0,
    LANE_WR_TXN  = 2'd1,
    LANE_RD_BEAT = 2'd2
  } lane_e;

  // Byte offsets decoded by software.
  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_MATCH = 8'h04;

  // Enable bit positions in the control register, indexed by lane.
  localparam int unsigned EN_BIT_RD_TXN  = 31;
  localparam int unsigned EN_BIT_WR_TXN  = 30;
  localparam int unsigned EN_BIT_RD_BEAT = 29;

  typedef struct packed {
    logic [FLT_LANES-1:0] en;
    logic [FLT_ID_W-1:0]  mask;
    logic [FLT_ID_W-1:0]  match;
  } flt_cfg_t;

  function automatic logic id_hit(input logic [FLT_ID_W-1:0] id,
                                  input logic [FLT_ID_W-1:0] match,
                                  input logic [FLT_ID_W-1:0] mask);
    return ((id ^ match) & mask) == '0;
  endfunction
endpackage

// File: rtl/flt_cfg_regs.sv
module flt_cfg_regs
  import axi_id_evt_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = FLT_DATA_W,
  parameter int unsigned ID_W   = FLT_ID_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [2:0]        en,
  output logic [ID_W-1:0]   mask,
  output logic [ID_W-1:0]   match
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_MATCH = ADDR_W'(OFS_MATCH);

  logic sel_ctrl, sel_match;
  assign sel_ctrl  = (addr == A_CTRL);
  assign sel_match = (addr == A_MATCH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en    <= '0;
      mask  <= '0;
      match <= '0;
    end else if (we) begin
      if (sel_ctrl) begin
        en[LANE_RD_TXN]  <= wdata[EN_BIT_RD_TXN];
        en[LANE_WR_TXN]  <= wdata[EN_BIT_WR_TXN];
        en[LANE_RD_BEAT] <= wdata[EN_BIT_RD_BEAT];
        mask             <= wdata[ID_W-1:0];
      end
      if (sel_match) begin
        match <= wdata[ID_W-1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_ctrl) begin
      rdata[ID_W-1:0]       = mask;
      rdata[EN_BIT_RD_TXN]  = en[LANE_RD_TXN];
      rdata[EN_BIT_WR_TXN]  = en[LANE_WR_TXN];
      rdata[EN_BIT_RD_BEAT] = en[LANE_RD_BEAT];
    end else if (sel_match) begin
      rdata[ID_W-1:0] = match;
    end
  end
endmodule

// File: rtl/flt_id_lane.sv
module flt_id_lane
  import axi_id_evt_pkg::*;
#(
  parameter int unsigned ID_W = FLT_ID_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid,
  input  logic            ready,
  input  logic [ID_W-1:0] id,
  input  logic [ID_W-1:0] match,
  input  logic [ID_W-1:0] mask,
  input  logic            enable,
  output logic            fire,
  output logic            hit,
  output logic            pulse
);
  assign fire = valid & ready;
  assign hit  = id_hit(id, match, mask);

  always_ff @(posedge clk) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= fire & hit & enable;
  end
endmodule

// File: rtl/axi_id_evt_filter.sv
module axi_id_evt_filter
  import axi_id_evt_pkg::*;
#(
  parameter int unsigned ID_W   = FLT_ID_W,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = FLT_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              ar_valid,
  input  logic              ar_ready,
  input  logic [ID_W-1:0]   ar_id,
  input  logic              aw_valid,
  input  logic              aw_ready,
  input  logic [ID_W-1:0]   aw_id,
  input  logic              r_valid,
  input  logic              r_ready,
  input  logic [ID_W-1:0]   r_id,
  output logic              evt_rd_txn,
  output logic              evt_wr_txn,
  output logic              evt_rd_beat
);
  localparam int unsigned LANES = FLT_LANES;

  logic [LANES-1:0] lane_en;
  logic [ID_W-1:0]  cfg_mask;
  logic [ID_W-1:0]  cfg_match;

  flt_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .en    (lane_en),
    .mask  (cfg_mask),
    .match (cfg_match)
  );

  logic [LANES-1:0] ch_valid, ch_ready, hs_fire, id_match, lane_pulse;
  logic [ID_W-1:0]  ch_id [LANES];

  assign ch_valid = {r_valid, aw_valid, ar_valid};
  assign ch_ready = {r_ready, aw_ready, ar_ready};
  assign ch_id[LANE_RD_TXN]  = ar_id;
  assign ch_id[LANE_WR_TXN]  = aw_id;
  assign ch_id[LANE_RD_BEAT] = r_id;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    flt_id_lane #(.ID_W(ID_W)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .valid  (ch_valid[g]),
      .ready  (ch_ready[g]),
      .id     (ch_id[g]),
      .match  (cfg_match),
      .mask   (cfg_mask),
      .enable (lane_en[g]),
      .fire   (hs_fire[g]),
      .hit    (id_match[g]),
      .pulse  (lane_pulse[g])
    );
  end

  assign evt_rd_txn  = lane_pulse[LANE_RD_TXN];
  assign evt_wr_txn  = lane_pulse[LANE_WR_TXN];
  assign evt_rd_beat = lane_pulse[LANE_RD_BEAT];
endmodule

// File: rtl/axi_id_evt_filter_chk.sv
module axi_id_evt_filter_chk #(
  parameter int unsigned ID_W   = 18,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic              ar_valid,
  input logic              ar_ready,
  input logic [ID_W-1:0]   ar_id,
  input logic              aw_valid,
  input logic              aw_ready,
  input logic              r_valid,
  input logic              r_ready,
  input logic [2:0]        lane_en,
  input logic [ID_W-1:0]   cfg_mask,
  input logic [ID_W-1:0]   cfg_match,
  input logic              evt_rd_txn,
  input logic              evt_wr_txn,
  input logic              evt_rd_beat
);
  AST_RD_TXN_HS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rd_txn |-> $past(ar_valid && ar_ready));  // R5
  AST_WR_TXN_HS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wr_txn |-> $past(aw_valid && aw_ready));  // R6
  AST_RD_BEAT_HS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rd_beat |-> $past(r_valid && r_ready));  // R7
  AST_NO_HS_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_valid && !ar_ready) |=> !evt_rd_txn);  // R8
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_en[0] |=> !evt_rd_txn);  // R9
  AST_ID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rd_txn |-> $past(((ar_id ^ cfg_match) & cfg_mask) == '0));  // R4
  AST_CTRL_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == 8'h00) |-> (cfg_rdata[28:18] == '0));  // R2
endmodule

bind axi_id_evt_filter axi_id_evt_filter_chk #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_addr    (cfg_addr),
  .cfg_rdata   (cfg_rdata),
  .ar_valid    (ar_valid),
  .ar_ready    (ar_ready),
  .ar_id       (ar_id),
  .aw_valid    (aw_valid),
  .aw_ready    (aw_ready),
  .r_valid     (r_valid),
  .r_ready     (r_ready),
  .lane_en     (lane_en),
  .cfg_mask    (cfg_mask),
  .cfg_match   (cfg_match),
  .evt_rd_txn  (evt_rd_txn),
  .evt_wr_txn  (evt_wr_txn),
  .evt_rd_beat (evt_rd_beat)
);

// File: tb/tb_axi_id_evt_filter.sv
module tb_axi_id_evt_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        ar_valid = 0, ar_ready = 0, aw_valid = 0, aw_ready = 0, r_valid = 0, r_ready = 0;
  logic [17:0] ar_id = '0, aw_id = '0, r_id = '0;
  logic        evt_rd_txn, evt_wr_txn, evt_rd_beat;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // Bench model of the registers
  logic [17:0] m_mask = '0, m_match = '0;
  logic        m_en_rt = 0, m_en_wt = 0, m_en_rb = 0;

  always #10 clk = ~clk;

  axi_id_evt_filter dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id),
    .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id),
    .evt_rd_txn(evt_rd_txn), .evt_wr_txn(evt_wr_txn), .evt_rd_beat(evt_rd_beat)
  );

  // R4: compare bit by bit, only where the mask bit is 1
  function automatic bit bench_match(input logic [17:0] id);
    for (int i = 0; i < 18; i++)
      if (m_mask[i] && (id[i] != m_match[i])) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [31:0] bench_read(input logic [7:0] a);
    if (a == 8'h00) return {m_en_rt, m_en_wt, m_en_rb, 11'd0, m_mask};
    if (a == 8'h04) return {14'd0, m_match};
    return 32'd0;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // One clock: expected outputs from inputs now on the pins and the model before any write
  task automatic step(input string req);
    bit e_rt, e_wt, e_rb;
    e_rt = ar_valid && ar_ready && m_en_rt && bench_match(ar_id);
    e_wt = aw_valid && aw_ready && m_en_wt && bench_match(aw_id);
    e_rb = r_valid && r_ready && m_en_rb && bench_match(r_id);
    if (cfg_we && rst_n) begin
      if (cfg_addr == 8'h00) begin
        m_en_rt = cfg_wdata[31]; m_en_wt = cfg_wdata[30]; m_en_rb = cfg_wdata[29];
        m_mask = cfg_wdata[17:0];
      end else if (cfg_addr == 8'h04) m_match = cfg_wdata[17:0];
    end
    @(posedge clk);
    @(negedge clk);
    chk({req, " rd_txn"}, {31'd0, evt_rd_txn}, {31'd0, e_rt});
    chk({req, " wr_txn"}, {31'd0, evt_wr_txn}, {31'd0, e_wt});
    chk({req, " rd_beat"}, {31'd0, evt_rd_beat}, {31'd0, e_rb});
  endtask

  task automatic idle();
    cfg_we = 0; ar_valid = 0; ar_ready = 0; aw_valid = 0; aw_ready = 0; r_valid = 0; r_ready = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    step("R12 write cycle");
    cfg_we = 0;
  endtask

  task automatic rd(input string req, input logic [7:0] a);
    cfg_addr = a;
    #1;
    chk(req, cfg_rdata, bench_read(a));
  endtask

  initial begin
    int cnt;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk("R1 ctrl", cfg_rdata, 32'd0);
    rd("R1 match reg", 8'h04);
    chk("R1 evt", {29'd0, evt_rd_txn, evt_wr_txn, evt_rd_beat}, 32'd0);

    // R2 / R3: field layout and read-back
    wr(8'h00, 32'hFFFF_FFFF);
    rd("R2 ctrl all ones", 8'h00);
    chk("R2 ctrl literal", cfg_rdata, 32'hE003_FFFF);
    wr(8'h04, 32'hFFFC_0005);
    rd("R3 match", 8'h04);
    chk("R3 match literal", cfg_rdata, 32'h0000_0005);

    // R7: burst of four matching beats -> four pulses
    cnt = 0;
    for (int b = 0; b < 4; b++) begin
      r_valid = 1; r_ready = 1; r_id = 18'h00005;
      step("R7 burst");
      cnt += evt_rd_beat;
    end
    idle();
    chk("R7 burst count", cnt, 4);

    // R4: mismatch in compared bit, then masked-off bit
    wr(8'h00, 32'hE003_FFFE);
    ar_valid = 1; ar_ready = 1; ar_id = 18'h00004;
    step("R4 masked-off bit differs");
    chk("R4 pulse", {31'd0, evt_rd_txn}, 32'd1);
    ar_id = 18'h00007;
    step("R4 compared bit differs");
    chk("R4 no pulse", {31'd0, evt_rd_txn}, 32'd0);

    // R8: valid without ready
    ar_id = 18'h00005; ar_ready = 0;
    aw_valid = 1; aw_id = 18'h00005; aw_ready = 0;
    step("R8 stalled");
    chk("R8 no pulse", {30'd0, evt_rd_txn, evt_wr_txn}, 32'd0);
    idle();

    // R9: only write enable cleared
    wr(8'h00, 32'hA003_FFFF);
    ar_valid = 1; ar_ready = 1; ar_id = 18'h5;
    aw_valid = 1; aw_ready = 1; aw_id = 18'h5;
    r_valid = 1; r_ready = 1; r_id = 18'h5;
    step("R9 wr disabled");
    chk("R9 evt", {29'd0, evt_rd_txn, evt_wr_txn, evt_rd_beat}, 32'h5);
    idle();

    // R10: zero mask matches everything
    wr(8'h00, 32'hE000_0000);
    aw_valid = 1; aw_ready = 1; aw_id = 18'h2ABCD;
    step("R10 zero mask");
    chk("R10 pulse", {31'd0, evt_wr_txn}, 32'd1);
    idle();

    // R11: stray offsets ignored
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h40, 32'h0000_1234);
    rd("R11 ctrl unchanged", 8'h00);
    rd("R11 match unchanged", 8'h04);
    rd("R11 stray reads zero", 8'h08);

    // R12: write on the same edge as a handshake uses old settings
    ar_valid = 1; ar_ready = 1; ar_id = 18'h3;
    cfg_we = 1; cfg_addr = 8'h00; cfg_wdata = 32'h0000_0000;
    step("R12 same-edge write");
    chk("R12 old enable", {31'd0, evt_rd_txn}, 32'd1);
    cfg_we = 0;
    step("R12 after write");
    chk("R12 new enable", {31'd0, evt_rd_txn}, 32'd0);
    idle();

    // Random traffic, R4-R9 and R12
    wr(8'h00, 32'hE003_FFF0);
    wr(8'h04, 32'h0000_1230);
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] rv;
      rv = $urandom();
      ar_valid = rv[0]; ar_ready = rv[1]; aw_valid = rv[2]; aw_ready = rv[3];
      r_valid = rv[4]; r_ready = rv[5];
      ar_id = 18'h01230 ^ {12'd0, rv[11:6]} ^ (rv[30] ? 18'h10000 : 18'h0);
      aw_id = 18'h01230 ^ {14'd0, rv[15:12]};
      r_id  = 18'h01230 ^ {12'd0, rv[21:16]};
      cfg_we = (rv[29:24] == 6'd0);
      cfg_addr = rv[31] ? 8'h04 : 8'h00;
      cfg_wdata = rv[31] ? {14'd0, 18'h01230 ^ {14'd0, rv[23:20]}}
                         : {rv[22:20], 11'd0, 18'h3FFF0 ^ {14'd0, rv[9:6]}};
      step("R5 R6 R7 random");
    end
    idle();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule